// File: doc/BRIEF.md
# I/O Translation Control Register Bank

This block is the host-visible register bank in front of an I/O address translation unit. A host bus issues single-word reads and writes at byte offsets. The bank holds the translation enable, the size of the translation window, the page-table base, two flush words, a captured fault record, arbiter and bus-slot configuration words, and an identification word. Each register keeps only its own writable bits, and some bits always read as one.

The translation datapath uses three outputs: the enable, the decoded window start address and the masked table base. When the datapath reports a failed lookup, the bank records the fault and raises an interrupt. The host drops that interrupt by reading or writing either fault register. Reads are combinational in the cycle of the request. Writes take effect at the next clock edge. Byte offsets are decoded as word indices, so the two lowest address bits are ignored.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset, reads return: control = IMPL_ID in bits 31:24 with all other bits 0; fault status = 0x00800000; arbiter enable (0x1008) = 0x00000003; arbitration enable (0x2000) = 0x00000008; mask ID (0x3018) = 0x23000000; every other register = 0. After reset, win_start, tbl_base, xlat_en and fault_irq are all 0.
- R2: The control register at offset 0x0000 keeps write bits 0 (enable) and 4:2 (range code). Bits 31:24 always read IMPL_ID and the other bits read 0. xlat_en follows bit 0.
- R3: A write to the control register sets win_start to 0xFFFFFFFF shifted left by 24 plus the range code. Code 0 gives 0xFF000000 (16 MB) and code 7 gives 0x80000000 (2 GB). No other access changes win_start.
- R4: The table base at offset 0x0004 keeps only bits under 0x07FFFC00. tbl_base shows the stored value.
- R5: The TLB flush word (0x0014) and the page flush word (0x0018) store every written bit.
- R6: A write to fault status (0x1000) stores the value ANDed with 0xFF0FFFFF, with bit 23 then set to 1. A write to fault address (0x1004) stores the full word. Either write clears fault_irq.
- R7: A read of fault status or fault address clears fault_irq at the next edge. Reads of other registers leave fault_irq unchanged.
- R8: Arbiter enable (0x1008) keeps bits under 0x801F000F and bit 0 always reads 1. Arbitration enable (0x2000) keeps bits under 0x001F0000 and bit 3 always reads 1.
- R9: The four slot configuration words at 0x1010 + 4*n keep bits under 0x00010003. Each word is independent of the others.
- R10: A write to mask ID (0x3018) ORs in the written bits ANDed with 0x00FFFFFF. No write clears a bit.
- R11: A read at an unmapped offset returns 0. A write at an unmapped offset changes no register.
- R12: A pulse on flt_valid sets fault_irq. It loads fault address with flt_page. It loads fault status with 0xC0820000, plus bit 18 when flt_read is 1.
- R13: When flt_valid and a host access to a fault register fall in the same cycle, the captured record is stored and fault_irq ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of a read request |
| flt_valid | input | 1 | Fault report from the translation datapath |
| flt_read | input | 1 | The faulting access was a read |
| flt_page | input | 32 | Faulting page address |
| xlat_en | output | 1 | Translation enable |
| win_start | output | 32 | Lowest address of the translation window |
| tbl_base | output | 32 | Masked page-table base |
| fault_irq | output | 1 | Fault interrupt |

## Verification
A fault report from the datapath and a host access that clears the interrupt can fall in the same cycle. That case is where the priority of the fault block matters. The bench drives flt_valid in the same cycle as a host write of zero to fault status, and again in the same cycle as a host read of fault address. Each time it expects the interrupt to stay high and the captured status and address to read back.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;

  localparam int unsigned DW = 32;

  // word indices (byte offset >> 2)
  localparam int W_CTRL   = 'h000;
  localparam int W_BASE   = 'h001;
  localparam int W_TFLUSH = 'h005;
  localparam int W_PFLUSH = 'h006;
  localparam int W_FSTAT  = 'h400;
  localparam int W_FADDR  = 'h401;
  localparam int W_ARBEN  = 'h402;
  localparam int W_SLOT0  = 'h404;
  localparam int W_SBARB  = 'h800;
  localparam int W_MASKID = 'hC06;

  localparam logic [DW-1:0] BASE_KEEP  = 32'h07FF_FC00;
  localparam logic [DW-1:0] FSTAT_KEEP = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] FSTAT_ONE  = 32'h0080_0000;
  localparam logic [DW-1:0] ARBEN_KEEP = 32'h801F_000F;
  localparam logic [DW-1:0] ARBEN_ONE  = 32'h0000_0001;
  localparam logic [DW-1:0] SLOT_KEEP  = 32'h0001_0003;
  localparam logic [DW-1:0] SBARB_KEEP = 32'h001F_0000;
  localparam logic [DW-1:0] SBARB_ONE  = 32'h0000_0008;
  localparam logic [DW-1:0] MASKID_KEEP = 32'h00FF_FFFF;

  localparam logic [DW-1:0] ARBEN_RST  = 32'h0000_0003;
  localparam logic [DW-1:0] MASKID_RST = 32'h2300_0000;

  // fault capture fields
  localparam logic [DW-1:0] FCAP_BASE = 32'hC082_0000; // err, late, fixed one, addr valid
  localparam logic [DW-1:0] FCAP_RD   = 32'h0004_0000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_BASE, SEL_TFLUSH, SEL_PFLUSH,
    SEL_FSTAT, SEL_FADDR, SEL_ARBEN, SEL_SLOT, SEL_SBARB, SEL_MASKID
  } reg_sel_e;

endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/xlat_reg_decode.sv
module xlat_reg_decode
  import xlat_regs_pkg::*;
#(
  parameter int AW    = 14,
  parameter int NSLOT = 4,
  parameter int SIW   = 2
) (
  input  logic [AW-1:0]  addr,
  output reg_sel_e       sel,
  output logic [SIW-1:0] slot_idx
);
  logic [AW-1:0]    waddr;
  logic [NSLOT-1:0] slot_hit;

  assign waddr = addr >> 2;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot_hit
    assign slot_hit[g] = (waddr == AW'(W_SLOT0 + g));
  end

  always_comb begin
    sel      = SEL_NONE;
    slot_idx = '0;
    case (waddr)
      AW'(W_CTRL):   sel = SEL_CTRL;
      AW'(W_BASE):   sel = SEL_BASE;
      AW'(W_TFLUSH): sel = SEL_TFLUSH;
      AW'(W_PFLUSH): sel = SEL_PFLUSH;
      AW'(W_FSTAT):  sel = SEL_FSTAT;
      AW'(W_FADDR):  sel = SEL_FADDR;
      AW'(W_ARBEN):  sel = SEL_ARBEN;
      AW'(W_SBARB):  sel = SEL_SBARB;
      AW'(W_MASKID): sel = SEL_MASKID;
      default:       sel = SEL_NONE;
    endcase
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_hit[i]) begin
        sel      = SEL_SLOT;
        slot_idx = SIW'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_window_dec.sv
module xlat_window_dec #(
  parameter int RW     = 3,
  parameter int MINLOG = 24
) (
  input  logic [RW-1:0] code,
  output logic [31:0]   start
);
  assign start = 32'hFFFF_FFFF << (MINLOG + int'(code));
endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
  import xlat_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_stat,
  input  logic          host_wr_addr,
  input  logic          host_touch,
  input  logic [DW-1:0] wdata,
  input  logic          cap_valid,
  input  logic          cap_read,
  input  logic [DW-1:0] cap_page,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] addr_q,
  output logic          irq_q
);
  logic [DW-1:0] stat_d, addr_d;
  logic          irq_d;
  logic          stat_en, addr_en, irq_en;

  always_comb begin
    stat_d  = stat_q;
    addr_d  = addr_q;
    irq_d   = irq_q;
    stat_en = 1'b0;
    addr_en = 1'b0;
    irq_en  = 1'b0;
    if (cap_valid) begin
      stat_d  = FCAP_BASE | (cap_read ? FCAP_RD : '0);
      addr_d  = cap_page;
      irq_d   = 1'b1;
      stat_en = 1'b1;
      addr_en = 1'b1;
      irq_en  = 1'b1;
    end else begin
      if (host_wr_stat) begin
        stat_d  = (wdata & FSTAT_KEEP) | FSTAT_ONE;
        stat_en = 1'b1;
      end
      if (host_wr_addr) begin
        addr_d  = wdata;
        addr_en = 1'b1;
      end
      if (host_touch) begin
        irq_d  = 1'b0;
        irq_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= FSTAT_ONE;
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (addr_en) addr_q <= addr_d;
      if (irq_en)  irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_regs_pkg::*;
#(
  parameter int          AW      = 14,
  parameter int          NSLOT   = 4,
  parameter int          RW      = 3,
  parameter logic [7:0]  IMPL_ID = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rd_data,
  input  logic          flt_valid,
  input  logic          flt_read,
  input  logic [31:0]   flt_page,
  output logic          xlat_en,
  output logic [31:0]   win_start,
  output logic [31:0]   tbl_base,
  output logic          fault_irq
);
  localparam int SIW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int RLO    = 2;
  localparam int RHI    = RLO + RW - 1;
  localparam int PADW   = 32 - 8 - RW - 2;

  logic rst_sn;
  xlat_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  reg_sel_e       sel;
  logic [SIW-1:0] slot_idx;
  xlat_reg_decode #(.AW(AW), .NSLOT(NSLOT), .SIW(SIW)) u_dec (
    .addr(req_addr), .sel(sel), .slot_idx(slot_idx)
  );

  logic wr_any, rd_any;
  assign wr_any = req_valid &  req_write;
  assign rd_any = req_valid & ~req_write;

  // clock enables
  logic en_ctrl, en_base, en_tfl, en_pfl, en_arb, en_sbarb, en_mask;
  assign en_ctrl  = wr_any && (sel == SEL_CTRL);
  assign en_base  = wr_any && (sel == SEL_BASE);
  assign en_tfl   = wr_any && (sel == SEL_TFLUSH);
  assign en_pfl   = wr_any && (sel == SEL_PFLUSH);
  assign en_arb   = wr_any && (sel == SEL_ARBEN);
  assign en_sbarb = wr_any && (sel == SEL_SBARB);
  assign en_mask  = wr_any && (sel == SEL_MASKID);

  // state
  logic          ctrl_en_q, ctrl_en_d;
  logic [RW-1:0] ctrl_rng_q, ctrl_rng_d;
  logic [31:0]   win_q, win_d;
  logic [31:0]   base_q, base_d;
  logic [31:0]   tfl_q, tfl_d;
  logic [31:0]   pfl_q, pfl_d;
  logic [31:0]   arb_q, arb_d;
  logic [31:0]   sbarb_q, sbarb_d;
  logic [31:0]   mask_q, mask_d;

  xlat_window_dec #(.RW(RW), .MINLOG(24)) u_win (
    .code(req_wdata[RHI:RLO]), .start(win_d)
  );

  always_comb begin
    ctrl_en_d  = req_wdata[0];
    ctrl_rng_d = req_wdata[RHI:RLO];
    base_d     = req_wdata & BASE_KEEP;
    tfl_d      = req_wdata;
    pfl_d      = req_wdata;
    arb_d      = (req_wdata & ARBEN_KEEP) | ARBEN_ONE;
    sbarb_d    = (req_wdata & SBARB_KEEP) | SBARB_ONE;
    mask_d     = mask_q | (req_wdata & MASKID_KEEP);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_en_q  <= 1'b0;
      ctrl_rng_q <= '0;
      win_q      <= '0;
      base_q     <= '0;
      tfl_q      <= '0;
      pfl_q      <= '0;
      arb_q      <= ARBEN_RST;
      sbarb_q    <= SBARB_ONE;
      mask_q     <= MASKID_RST;
    end else begin
      if (en_ctrl) begin
        ctrl_en_q  <= ctrl_en_d;
        ctrl_rng_q <= ctrl_rng_d;
        win_q      <= win_d;
      end
      if (en_base)  base_q  <= base_d;
      if (en_tfl)   tfl_q   <= tfl_d;
      if (en_pfl)   pfl_q   <= pfl_d;
      if (en_arb)   arb_q   <= arb_d;
      if (en_sbarb) sbarb_q <= sbarb_d;
      if (en_mask)  mask_q  <= mask_d;
    end
  end

  // per-slot configuration words
  logic [31:0] slot_rd [NSLOT];
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic        en;
    logic [31:0] d, q;
    assign en = wr_any && (sel == SEL_SLOT) && (slot_idx == SIW'(g));
    assign d  = req_wdata & SLOT_KEEP;
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)  q <= '0;
      else if (en)  q <= d;
    end
    assign slot_rd[g] = q;
  end

  // fault record
  logic [31:0] fstat_q, faddr_q;
  logic        irq_q;
  logic        hit_fault;
  assign hit_fault = (sel == SEL_FSTAT) || (sel == SEL_FADDR);

  xlat_fault_unit u_flt (
    .clk(clk), .rst_n(rst_sn),
    .host_wr_stat(wr_any && (sel == SEL_FSTAT)),
    .host_wr_addr(wr_any && (sel == SEL_FADDR)),
    .host_touch(req_valid && hit_fault),
    .wdata(req_wdata),
    .cap_valid(flt_valid), .cap_read(flt_read), .cap_page(flt_page),
    .stat_q(fstat_q), .addr_q(faddr_q), .irq_q(irq_q)
  );

  // read path
  always_comb begin
    rd_data = '0;
    if (rd_any) begin
      case (sel)
        SEL_CTRL:   rd_data = {IMPL_ID, {PADW{1'b0}}, ctrl_rng_q, 1'b0, ctrl_en_q};
        SEL_BASE:   rd_data = base_q;
        SEL_TFLUSH: rd_data = tfl_q;
        SEL_PFLUSH: rd_data = pfl_q;
        SEL_FSTAT:  rd_data = fstat_q;
        SEL_FADDR:  rd_data = faddr_q;
        SEL_ARBEN:  rd_data = arb_q;
        SEL_SLOT:   rd_data = slot_rd[slot_idx];
        SEL_SBARB:  rd_data = sbarb_q;
        SEL_MASKID: rd_data = mask_q;
        default:    rd_data = '0;
      endcase
    end
  end

  assign xlat_en   = ctrl_en_q;
  assign win_start = win_q;
  assign tbl_base  = base_q;
  assign fault_irq = irq_q;
endmodule

// File: rtl/xlat_ctl_regs_chk.sv
module xlat_ctl_regs_chk
  import xlat_regs_pkg::*;
#(
  parameter int         AW      = 14,
  parameter logic [7:0] IMPL_ID = 8'h00
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   rd_data,
  input logic          flt_valid,
  input logic [31:0]   win_start,
  input logic [31:0]   tbl_base,
  input logic          fault_irq
);
  logic [AW-1:0] w;
  logic          to_fault, to_ctrl;
  assign w        = req_addr >> 2;
  assign to_fault = (w == AW'(W_FSTAT)) || (w == AW'(W_FADDR));
  assign to_ctrl  = (w == AW'(W_CTRL));

  // R12: a fault report raises the interrupt
  p_irq_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> fault_irq);

  // R6 / R7: host touching a fault register with no report drops it
  p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && to_fault && !flt_valid) |=> !fault_irq);

  // R2: identification byte on control reads
  p_ctrl_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && to_ctrl) |-> (rd_data[31:24] == IMPL_ID));

  // R3: window start moves only on control writes
  p_win_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && to_ctrl) |=> $stable(win_start));

  // R3: window start is zero or a high-aligned mask
  p_win_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start != 32'h0) |-> (win_start[31] && (win_start[23:0] == 24'h0)));

  // R4: base output carries only kept bits
  p_base_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((tbl_base & ~BASE_KEEP) == 32'h0));
endmodule

bind xlat_ctl_regs xlat_ctl_regs_chk #(.AW(AW), .IMPL_ID(IMPL_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rd_data(rd_data), .flt_valid(flt_valid),
  .win_start(win_start), .tbl_base(tbl_base), .fault_irq(fault_irq)
);

// File: tb/xlat_ctl_regs_test.sv
`timescale 1ns/1ps
module xlat_ctl_regs_test;
  localparam int         AW   = 14;
  localparam logic [7:0] IDV  = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata, rd_data;
  logic          flt_valid, flt_read;
  logic [31:0]   flt_page;
  logic          xlat_en, fault_irq;
  logic [31:0]   win_start, tbl_base;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_ctl_regs #(.AW(AW), .IMPL_ID(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .flt_valid(flt_valid), .flt_read(flt_read), .flt_page(flt_page),
    .xlat_en(xlat_en), .win_start(win_start), .tbl_base(tbl_base),
    .fault_irq(fault_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(off); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input int off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(off);
    #1 check(tag, rd_data, exp);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fault(input logic rdf, input logic [31:0] pg);
    @(negedge clk);
    flt_valid = 1'b1; flt_read = rdf; flt_page = pg;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  function automatic bit mapped(input int w);
    return (w == 'h0) || (w == 'h1) || (w == 'h5) || (w == 'h6) ||
           (w >= 'h400 && w <= 'h402) || (w >= 'h404 && w <= 'h407) ||
           (w == 'h800) || (w == 'hC06);
  endfunction

  function automatic logic [31:0] slot_pat(input int n);
    return 32'h9E37_79B9 * (n + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; flt_valid = 1'b0; flt_read = 1'b0; flt_page = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    check("R1 win_start", win_start, 32'h0);
    check("R1 tbl_base", tbl_base, 32'h0);
    check("R1 xlat_en", {31'h0, xlat_en}, 32'h0);
    check("R1 fault_irq", {31'h0, fault_irq}, 32'h0);
    rd_chk('h0000, {IDV, 24'h0}, "R1 ctrl");
    rd_chk('h0004, 32'h0, "R1 base");
    rd_chk('h0014, 32'h0, "R1 tflush");
    rd_chk('h0018, 32'h0, "R1 pflush");
    rd_chk('h1000, 32'h0080_0000, "R1 fstat");
    rd_chk('h1004, 32'h0, "R1 faddr");
    rd_chk('h1008, 32'h3, "R1 arben");
    for (int n = 0; n < 4; n++) rd_chk('h1010 + 4*n, 32'h0, "R1 slot");
    rd_chk('h2000, 32'h8, "R1 sbarb");
    rd_chk('h3018, 32'h2300_0000, "R1 maskid");

    // R2 / R3 all range codes
    for (int c = 0; c < 8; c++) begin
      logic [31:0] v;
      v = 32'hFFFF_FFE2 | (32'(c) << 2) | 32'(c & 1);
      wr('h0000, v);
      #1;
      check("R3 win_start", win_start, 32'hFFFF_FFFF << (24 + c));
      check("R2 xlat_en", {31'h0, xlat_en}, 32'(c & 1));
      rd_chk('h0000, {IDV, 19'h0, 3'(c), 1'b0, 1'(c & 1)}, "R2 ctrl");
    end
    wr('h0004, 32'hFFFF_FFFF);
    #1 check("R3 win hold", win_start, 32'h8000_0000);

    // R4
    #1 check("R4 tbl_base", tbl_base, 32'h07FF_FC00);
    rd_chk('h0004, 32'h07FF_FC00, "R4 base all ones");
    wr('h0004, 32'h1234_5678);
    rd_chk('h0004, 32'h1234_5678 & 32'h07FF_FC00, "R4 base pattern");

    // R5
    wr('h0014, 32'hA5A5_5A5A);
    wr('h0018, 32'hFFFF_FFFF);
    rd_chk('h0014, 32'hA5A5_5A5A, "R5 tflush");
    rd_chk('h0018, 32'hFFFF_FFFF, "R5 pflush");

    // R8
    wr('h1008, 32'h0);
    rd_chk('h1008, 32'h1, "R8 arben zero");
    wr('h1008, 32'hFFFF_FFFF);
    rd_chk('h1008, 32'h801F_000F, "R8 arben ones");
    wr('h2000, 32'h0);
    rd_chk('h2000, 32'h8, "R8 sbarb zero");
    wr('h2000, 32'hFFFF_FFFF);
    rd_chk('h2000, 32'h001F_0008, "R8 sbarb ones");

    // R9
    for (int n = 0; n < 4; n++) wr('h1010 + 4*n, slot_pat(n));
    for (int n = 0; n < 4; n++) rd_chk('h1010 + 4*n, slot_pat(n) & 32'h0001_0003, "R9 slot");

    // R10
    wr('h3018, 32'h0000_00F0);
    rd_chk('h3018, 32'h2300_00F0, "R10 maskid or");
    wr('h3018, 32'hFF00_000F);
    rd_chk('h3018, 32'h2300_00FF, "R10 maskid top masked");
    wr('h3018, 32'h0);
    rd_chk('h3018, 32'h2300_00FF, "R10 maskid no clear");

    // R6 host writes
    wr('h1000, 32'hFFFF_FFFF);
    rd_chk('h1000, 32'hFF8F_FFFF, "R6 fstat ones");
    wr('h1000, 32'h0);
    rd_chk('h1000, 32'h0080_0000, "R6 fstat zero");
    wr('h1004, 32'hDEAD_BEEF);
    rd_chk('h1004, 32'hDEAD_BEEF, "R6 faddr");

    // R12 / R7 capture and read clear
    fault(1'b1, 32'h1234_5000);
    #1 check("R12 irq set", {31'h0, fault_irq}, 32'h1);
    rd_chk('h1000, 32'hC086_0000, "R12 fstat read fault");
    #1 check("R7 irq clr by fstat read", {31'h0, fault_irq}, 32'h0);
    fault(1'b0, 32'hABCD_E000);
    rd_chk('h0004, 32'h0234_5400, "R7 other read");
    #1 check("R7 irq kept by other read", {31'h0, fault_irq}, 32'h1);
    rd_chk('h1004, 32'hABCD_E000, "R12 faddr");
    #1 check("R7 irq clr by faddr read", {31'h0, fault_irq}, 32'h0);
    rd_chk('h1000, 32'hC082_0000, "R12 fstat write fault");

    // R6 writes clear
    fault(1'b0, 32'h0000_1000);
    wr('h1004, 32'h0);
    #1 check("R6 irq clr by faddr write", {31'h0, fault_irq}, 32'h0);
    fault(1'b0, 32'h0000_2000);
    wr('h1000, 32'h0);
    #1 check("R6 irq clr by fstat write", {31'h0, fault_irq}, 32'h0);

    // R13 same-cycle collisions
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'('h1000); req_wdata = 32'h0;
    flt_valid = 1'b1; flt_read = 1'b1; flt_page = 32'h7777_7000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; flt_valid = 1'b0;
    #1 check("R13 irq after write collision", {31'h0, fault_irq}, 32'h1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'('h1004);
    flt_valid = 1'b1; flt_read = 1'b0; flt_page = 32'h5555_5000;
    @(negedge clk);
    req_valid = 1'b0; flt_valid = 1'b0;
    #1 check("R13 irq after read collision", {31'h0, fault_irq}, 32'h1);
    rd_chk('h1004, 32'h5555_5000, "R13 faddr");
    wr('h1000, 32'h0);
    fault(1'b1, 32'h1);
    rd_chk('h1000, 32'hC086_0000, "R13 fstat capture kept");

    // R11 sweep every unmapped word
    for (int wi = 0; wi < (1 << (AW - 2)); wi++) begin
      if (!mapped(wi)) begin
        wr(wi * 4, 32'hFFFF_FFFF);
        rd_chk(wi * 4, 32'h0, "R11 unmapped read");
      end
    end
    rd_chk('h0000, {IDV, 24'h0000_1D}, "R11 ctrl kept");
    rd_chk('h0004, 32'h0234_5400, "R11 base kept");
    rd_chk('h0014, 32'hA5A5_5A5A, "R11 tflush kept");
    rd_chk('h1008, 32'h801F_000F, "R11 arben kept");
    rd_chk('h2000, 32'h001F_0008, "R11 sbarb kept");
    rd_chk('h3018, 32'h2300_00FF, "R11 maskid kept");
    for (int n = 0; n < 4; n++) rd_chk('h1010 + 4*n, slot_pat(n) & 32'h0001_0003, "R11 slot kept");
    #1 check("R11 win kept", win_start, 32'h8000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule